// File: doc/BRIEF.md
# Center-Aligned PWM Dead-Time Channel

This block is one output channel that turns a shared up/down time base into a center-aligned PWM waveform, with dead time added to one edge of each pulse. A duty register sets the ideal pulse and is compared with the shared count. A dead-time register is compared with a small counter local to the channel. The channel adds the delay by moving its comparison from the shared count to the local counter for a short time and then moving back.

A 7-bit mode word selects the delayed edge and which edges raise a sticky event flag. The channel changes state only on cycles where the prescaled tick enable is high, so the local counter runs at the same rate as the shared count. The shared counter, interrupt routing and bus access are outside the block.

Top module: `cpwm_dt_channel`

## Requirements
- R1: The mode word is accepted only when bits 6..2 equal 5'b00111. For any other code the output keeps its current value and the event flag is not set.
- R2: Trailing mode (mode bit 0 = 0): at the first duty match (shared count equal to the duty value) the output takes the polarity value. At the next duty match the local counter restarts. D+1 ticks later, where D is the dead value, the output returns to the complement of polarity.
- R3: Leading mode (mode bit 0 = 1): at the first duty match the local counter restarts. D+1 ticks later the output takes the polarity value. At the next duty match the output returns to the complement of polarity. The cycle repeats on the following matches.
- R4: When mode bit 1 = 0, the flag is set only when the output returns to the complement of polarity (the trailing edge of the pulse).
- R5: When mode bit 1 = 1, the flag is set on both edges of the pulse.
- R6: The flag stays set until a clear pulse arrives. If a clear and a new edge event fall on the same cycle, the flag stays set.
- R7: The local counter advances, and compares are made, only on cycles with the tick enable high. Output and flag hold on all other cycles.
- R8: While reset is low, the output goes to the complement of polarity and the flag goes to 0. After reset the channel compares against the shared count and waits for a first duty match.
- R9: A dead value of 0 still delays the affected edge by exactly one tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Prescaled tick enable |
| bus_cnt | input | CNT_W | Shared up/down count value |
| mode | input | 7 | Mode word (bit 0 edge select, bit 1 flag edges, bits 6..2 must be 00111) |
| out_pol | input | 1 | Active level of the pulse |
| duty_val | input | CNT_W | Ideal duty compare value |
| dead_val | input | CNT_W | Dead-time compare value |
| flag_clr | input | 1 | One-cycle clear of the event flag |
| pwm_out | output | 1 | PWM output |
| evt_flag | output | 1 | Sticky edge event flag |

## Verification
The bench drives a triangular count and measures active widths over whole periods. A design that drops the extra restart tick, or that puts the delay on the wrong edge, gives pulses that are one tick off or that grow where they should shrink. Zero dead time is checked on both edge modes, because a channel that never matches a counter of zero would stay locked in the dead phase. Other tests run a half-rate tick and change to an unsupported mode in the middle of a pulse. These catch compares made on cycles without a tick and an output that keeps moving under an invalid code. The bench also holds the flag clear high while edge events arrive, which shows whether the set wins over the clear.

// File: rtl/cpwm_pkg.sv
// Package: types shared by the dead-time PWM channel.
// Assumes: nothing beyond the standard language.
package cpwm_pkg;

    // Sequence position inside one PWM period.
    typedef enum logic [1:0] {
        ST_FIRST  = 2'd0,   // waiting for the first duty match of the period
        ST_DEAD   = 2'd1,   // comparing the local counter with the dead value
        ST_SECOND = 2'd2    // waiting for the second duty match of the period
    } seq_st_e;

    localparam logic [4:0] MODE_FAMILY = 5'b00111;

    // True when the upper mode bits select this channel's function.
    function automatic logic mode_valid(input logic [6:0] m);
        return m[6:2] == MODE_FAMILY;
    endfunction

endpackage

// File: rtl/cpwm_dead_cnt.sv
// Module: local dead-time counter.
// Does: restarts at zero on a clear request and otherwise counts ticks.
// Assumes: clear and tick come from the same prescaled domain as the shared count.
module cpwm_dead_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    // Counter register: a clear wins, otherwise step once per tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (tick_en) begin
            cnt <= cnt + ONE;
        end
    end

    a_r7_cnt_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !tick_en && !clr) |=> $stable(cnt));

endmodule

// File: rtl/cpwm_seq_fsm.sv
// Module: edge sequencer of the dead-time PWM channel.
// Does: picks the compare source (shared count or local counter), steps
//       through the leading- or trailing-edge sequence and drives the output.
// Assumes: bus_cnt counts up then down; only acts when tick_en and mode_ok are high.
module cpwm_seq_fsm
    import cpwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             mode_ok,
    input  logic             lead_mode,
    input  logic             out_pol,
    input  logic [CNT_W-1:0] bus_cnt,
    input  logic [CNT_W-1:0] duty_val,
    input  logic [CNT_W-1:0] dead_val,
    input  logic [CNT_W-1:0] loc_cnt,
    output logic             cnt_clr,
    output logic             pwm_out,
    output logic             ev_lead,
    output logic             ev_trail
);

    seq_st_e state_q, state_d;
    logic    pwm_d;
    logic    use_local;
    logic    step;
    logic    duty_hit;
    logic    dead_hit;

    // Compare source select and the two match detectors.
    always_comb begin
        use_local = (state_q == ST_DEAD);
        step      = tick_en && mode_ok;
        duty_hit  = step && !use_local && (bus_cnt == duty_val);
        dead_hit  = step && use_local && (loc_cnt == dead_val);
    end

    // Next state, output level, counter restart and edge events.
    always_comb begin
        state_d  = state_q;
        pwm_d    = pwm_out;
        cnt_clr  = 1'b0;
        ev_lead  = 1'b0;
        ev_trail = 1'b0;
        unique case (state_q)
            ST_FIRST: begin
                if (duty_hit) begin
                    if (lead_mode) begin
                        cnt_clr = 1'b1;
                        state_d = ST_DEAD;
                    end else begin
                        pwm_d   = out_pol;
                        ev_lead = 1'b1;
                        state_d = ST_SECOND;
                    end
                end
            end
            ST_SECOND: begin
                if (duty_hit) begin
                    if (lead_mode) begin
                        pwm_d    = !out_pol;
                        ev_trail = 1'b1;
                        state_d  = ST_FIRST;
                    end else begin
                        cnt_clr = 1'b1;
                        state_d = ST_DEAD;
                    end
                end
            end
            ST_DEAD: begin
                if (dead_hit) begin
                    if (lead_mode) begin
                        pwm_d   = out_pol;
                        ev_lead = 1'b1;
                        state_d = ST_SECOND;
                    end else begin
                        pwm_d    = !out_pol;
                        ev_trail = 1'b1;
                        state_d  = ST_FIRST;
                    end
                end
            end
            default: begin
                state_d = ST_FIRST;
            end
        endcase
    end

    // Sequence and output registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FIRST;
            pwm_out <= !out_pol;
        end else begin
            state_q <= state_d;
            pwm_out <= pwm_d;
        end
    end

    a_r8_reset_level: assert property (@(posedge clk)
        !rst_n |=> (pwm_out == !$past(out_pol)));

    a_r7_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !tick_en) |=> $stable(pwm_out));

    a_r2_one_event: assert property (@(posedge clk) disable iff (!rst_n)
        !(ev_lead && ev_trail));

endmodule

// File: rtl/cpwm_evt_flag.sv
// Module: sticky event flag.
// Does: sets on an edge event and clears on request; a set wins over a clear.
// Assumes: set and clear are single-cycle pulses in the clk domain.
module cpwm_evt_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_req,
    output logic flag
);

    // Flag register: set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (set_evt) begin
            flag <= 1'b1;
        end else if (clr_req) begin
            flag <= 1'b0;
        end
    end

    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && set_evt) |=> flag);

    a_r8_flag_reset: assert property (@(posedge clk)
        !rst_n |=> !flag);

endmodule

// File: rtl/cpwm_dt_channel.sv
// Module: center-aligned PWM channel with dead-time insertion (top).
// Does: decodes the mode word, joins the sequencer, the local counter and
//       the sticky flag, and picks which edges raise the flag.
// Assumes: the shared up/down count and tick_en come from one prescaler.
module cpwm_dt_channel
    import cpwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic [CNT_W-1:0] bus_cnt,
    input  logic [6:0]       mode,
    input  logic             out_pol,
    input  logic [CNT_W-1:0] duty_val,
    input  logic [CNT_W-1:0] dead_val,
    input  logic             flag_clr,
    output logic             pwm_out,
    output logic             evt_flag
);

    logic             mode_ok;
    logic             lead_mode;
    logic             both_edges;
    logic             cnt_clr;
    logic             ev_lead;
    logic             ev_trail;
    logic             flag_set;
    logic [CNT_W-1:0] loc_cnt;

    // Mode decode and flag source selection.
    always_comb begin
        mode_ok    = mode_valid(mode);
        lead_mode  = mode[0];
        both_edges = mode[1];
        flag_set   = ev_trail || (both_edges && ev_lead);
    end

    cpwm_dead_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .clr     (cnt_clr),
        .cnt     (loc_cnt)
    );

    cpwm_seq_fsm #(.CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .mode_ok   (mode_ok),
        .lead_mode (lead_mode),
        .out_pol   (out_pol),
        .bus_cnt   (bus_cnt),
        .duty_val  (duty_val),
        .dead_val  (dead_val),
        .loc_cnt   (loc_cnt),
        .cnt_clr   (cnt_clr),
        .pwm_out   (pwm_out),
        .ev_lead   (ev_lead),
        .ev_trail  (ev_trail)
    );

    cpwm_evt_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (flag_set),
        .clr_req (flag_clr),
        .flag    (evt_flag)
    );

    a_r1_invalid_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !mode_ok) |=> ($stable(pwm_out) && !$rose(evt_flag)));

    a_r4_trail_only: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(evt_flag) && !$past(mode[1])) |-> (pwm_out == !$past(out_pol)));

    a_r5_edge_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && mode_ok && both_edges && tick_en && ev_lead) |=> evt_flag);

endmodule

// File: tb/cpwm_dt_channel_bench.sv
module cpwm_dt_channel_bench;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 16;
    localparam int PEAK       = 20;
    localparam int PER        = 2 * PEAK;
    localparam int NPER       = 3;
    localparam int NVEC       = 6;

    typedef struct packed {
        logic       lead;
        logic       both;
        logic       pol;
        logic [7:0] duty;
        logic [7:0] dead;
    } vec_t;

    // lead, both, pol, duty, dead
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 1'b0, 1'b1, 8'd10, 8'd3},
        '{1'b1, 1'b0, 1'b1, 8'd10, 8'd3},
        '{1'b0, 1'b1, 1'b0, 8'd8,  8'd5},
        '{1'b1, 1'b1, 1'b1, 8'd12, 8'd0},
        '{1'b0, 1'b0, 1'b0, 8'd15, 8'd0},
        '{1'b1, 1'b1, 1'b0, 8'd5,  8'd2}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick_en = 1'b1;
    logic [CNT_W-1:0] bus_cnt = '0;
    logic [6:0]       mode = 7'b0011100;
    logic             out_pol = 1'b1;
    logic [CNT_W-1:0] duty_val = '0;
    logic [CNT_W-1:0] dead_val = '0;
    logic             flag_clr = 1'b1;
    logic             pwm_out;
    logic             evt_flag;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cpwm_dt_channel #(.CNT_W(CNT_W)) u_cpwm_dt_channel (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .bus_cnt  (bus_cnt),
        .mode     (mode),
        .out_pol  (out_pol),
        .duty_val (duty_val),
        .dead_val (dead_val),
        .flag_clr (flag_clr),
        .pwm_out  (pwm_out),
        .evt_flag (evt_flag)
    );

    task automatic check(input bit ok, input string req, input int got, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic do_reset(input bit lead, input bit both, input bit pol,
                            input int duty, input int dead);
        @(negedge clk);
        rst_n    = 1'b0;
        tick_en  = 1'b1;
        bus_cnt  = '0;
        mode     = {5'b00111, both, lead};
        out_pol  = pol;
        duty_val = CNT_W'(duty);
        dead_val = CNT_W'(dead);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Drive a triangular count from 0; count active and flag samples.
    task automatic run_window(input int n_ticks, input bit half,
                              output int act, output int fhi, output int flead);
        act = 0; fhi = 0; flead = 0;
        for (int c = 0; c < (half ? 2 * n_ticks : n_ticks); c++) begin
            int k = half ? c / 2 : c;
            int m = k % PER;
            bus_cnt = CNT_W'((m <= PEAK) ? m : PER - m);
            tick_en = half ? (c % 2 == 0) : 1'b1;
            @(posedge clk);
            @(negedge clk);
            if (pwm_out === out_pol) act++;
            if (evt_flag === 1'b1) fhi++;
            if (evt_flag === 1'b1 && pwm_out === out_pol) flead++;
        end
        tick_en = 1'b1;
    endtask

    initial begin
        while (cyc < 60000) begin
            @(posedge clk);
            cyc++;
        end
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got %0d expected %0d", cyc, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int act, fhi, flead, width, exp_ev;

        // R8: reset level for both polarities.
        do_reset(1'b0, 1'b0, 1'b1, 10, 3);
        check(pwm_out === 1'b0, "R8 pol1 out", int'(pwm_out), 0);
        check(evt_flag === 1'b0, "R8 flag", int'(evt_flag), 0);
        do_reset(1'b0, 1'b0, 1'b0, 10, 3);
        check(pwm_out === 1'b1, "R8 pol0 out", int'(pwm_out), 1);

        // R2 R3 R4 R5 R6 R9: vector table, flag clear held high.
        flag_clr = 1'b1;
        for (int v = 0; v < NVEC; v++) begin
            do_reset(VECS[v].lead, VECS[v].both, VECS[v].pol,
                     int'(VECS[v].duty), int'(VECS[v].dead));
            run_window(NPER * PER, 1'b0, act, fhi, flead);
            width = VECS[v].lead
                  ? 2 * (PEAK - int'(VECS[v].duty)) - int'(VECS[v].dead) - 1
                  : 2 * (PEAK - int'(VECS[v].duty)) + int'(VECS[v].dead) + 1;
            exp_ev = VECS[v].both ? 2 * NPER : NPER;
            check(act == NPER * width,
                  VECS[v].lead ? "R3/R9 lead width" : "R2/R9 trail width",
                  act, NPER * width);
            check(fhi == exp_ev, "R6 set wins over held clear", fhi, exp_ev);
            check(flead == (VECS[v].both ? NPER : 0),
                  VECS[v].both ? "R5 both edges" : "R4 trailing only",
                  flead, VECS[v].both ? NPER : 0);
        end

        // R7: half-rate tick doubles every duration in clock cycles.
        do_reset(1'b0, 1'b0, 1'b1, 10, 3);
        run_window(NPER * PER, 1'b1, act, fhi, flead);
        check(act == 2 * NPER * 24, "R7 half tick width", act, 2 * NPER * 24);
        check(fhi == NPER, "R7 half tick events", fhi, NPER);

        // R1: invalid code mid-pulse holds the output and raises no flag.
        do_reset(1'b0, 1'b0, 1'b1, 10, 3);
        run_window(16, 1'b0, act, fhi, flead);
        check(pwm_out === 1'b1, "R1 active before switch", int'(pwm_out), 1);
        mode = 7'b0000000;
        run_window(2 * PER, 1'b0, act, fhi, flead);
        check(act == 2 * PER, "R1 invalid holds output", act, 2 * PER);
        check(fhi == 0, "R1 invalid no flag", fhi, 0);
        mode = 7'b1011100;
        run_window(PER, 1'b0, act, fhi, flead);
        check(act == PER && fhi == 0, "R1 near-miss code holds", act, PER);

        // R6: sticky without clear, then a single clear pulse.
        flag_clr = 1'b0;
        do_reset(1'b0, 1'b0, 1'b1, 10, 3);
        run_window(PER, 1'b0, act, fhi, flead);
        check(fhi == 6, "R6 flag sticky", fhi, 6);
        check(evt_flag === 1'b1, "R6 flag still set", int'(evt_flag), 1);
        tick_en  = 1'b0;
        flag_clr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        flag_clr = 1'b0;
        check(evt_flag === 1'b0, "R6 clear pulse", int'(evt_flag), 0);
        @(posedge clk);
        @(negedge clk);
        check(evt_flag === 1'b0 && pwm_out === 1'b0, "R7 no tick holds", int'(evt_flag), 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule